// File: doc/BRIEF.md
# Fuse Word Read Sequencer

This block reads a run of consecutive 32-bit words out of a one-time-programmable fuse macro by driving the macro's control pins itself. A client presents a start index and a word count on a valid/ready request port. If the range fits inside the array, the sequencer brings the macro out of deep standby, turns on the repair function and then chip enable. For each word it puts the index on the macro address pins and gives one timed macro clock pulse. It captures the read data and offers the word on a valid/ready output stream. After the last word is taken it powers the macro down in reverse order and pulses `done`. A range that does not fit gets a one-cycle `err` pulse, and no macro pin moves.

The high and low phases of the macro clock are given in nanoseconds and turned into system clock cycles from the `CLK_HZ` parameter, rounding up. The state machine has eleven states:
- `S_IDLE`: waiting for a request.
- `S_UP_STBY`, `S_UP_TRIM`, `S_UP_CE`: the three power-up steps.
- `S_ADDR`: address setup.
- `S_CLK_HI` and `S_CLK_LO`: the timed clock pulse.
- `S_EMIT`: the word is offered on the output.
- `S_DN_CE`, `S_DN_TRIM`, `S_FINISH`: the power-down steps.

The transitions are:
- `S_IDLE` to `S_UP_STBY` on an accepted request.
- Each power-up step to the next after one cycle, then `S_UP_CE` to `S_ADDR` to `S_CLK_HI`.
- `S_CLK_HI` to `S_CLK_LO` to `S_EMIT`, each when its interval timer expires.
- `S_EMIT` to `S_ADDR` on acceptance of a word that is not the last.
- `S_EMIT` to `S_DN_CE` on acceptance of the last word.
- `S_DN_CE` to `S_DN_TRIM` to `S_FINISH` to `S_IDLE`, one cycle each.

Top module: `otp_read_seq`

## Requirements
- R1: Reset state:
  - `req_ready` is 1.
  - `otp_stby_n`, `otp_trim`, `otp_ce` and `otp_clk` are 0.
  - `out_valid`, `done` and `err` are 0.
- R2: A request with count 0, start index >= WORDS, or start+count > WORDS is rejected. `err` is 1 in the cycle after acceptance and lasts one cycle. No macro pin (standby, repair, enable, clock, address) changes, and `req_ready` stays 1.
- R3: After an accepted request, `otp_stby_n` rises, then `otp_trim` one cycle later, then `otp_ce` one cycle after that, all before the first macro clock pulse.
- R4: `otp_addr` holds the word index for at least one cycle before `otp_clk` rises and stays unchanged while `otp_clk` is high. `otp_clk` is high for exactly HI_CYC cycles.
- R5: `otp_clk` stays low for at least LO_CYC cycles before `out_valid` rises. The word offered is the `otp_rdata` value present at the end of that low interval.
- R6: Words come out in ascending index order starting at the requested index, exactly count of them.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold and `otp_clk` stays low. No new pulse starts until the word is accepted.
- R8: After the last word is accepted:
  - `otp_ce` falls first.
  - `otp_trim` falls one cycle later.
  - `otp_stby_n` falls one cycle after that, in the same cycle that `done` is 1 for one cycle.
- R9: `otp_prog`, `otp_we` and `otp_tmode` are 0 at all times.
- R10: HI_CYC = ceil(CLK_HZ*ACCESS_NS/1e9) and LO_CYC = ceil(CLK_HZ*LOW_NS/1e9), each at least 1.
- R11: `req_ready` is 0 from acceptance of a good request until `done`, so no request can start while the macro is powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_idx | input | AW+1 | First word index |
| req_cnt | input | AW+1 | Number of words |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer takes word |
| out_data | output | DATA_W | Word read from the array |
| err | output | 1 | One-cycle pulse: request out of range |
| done | output | 1 | One-cycle pulse: run finished and macro powered down |
| otp_addr | output | AW | Macro word address |
| otp_clk | output | 1 | Macro read clock |
| otp_ce | output | 1 | Macro chip enable |
| otp_trim | output | 1 | Macro repair function enable |
| otp_stby_n | output | 1 | Macro deep standby, active low |
| otp_prog | output | 1 | Macro program enable, held 0 |
| otp_we | output | 1 | Macro write pulse, held 0 |
| otp_tmode | output | 1 | Macro test mode select, held 0 |
| otp_rdata | input | DATA_W | Macro read data |

## Verification
A state register that lands in a wrong state shows at the macro pins within one cycle: the standby, repair, enable and clock pins are decoded straight from the state. Such an error breaks the nesting of enables or produces a clock pulse without chip enable. A wrong remaining-word count or address counter shows as a missing, extra or out-of-order word the first time a word is accepted. The scoreboard sees it within one word time. A timer fault shows as a clock high width that differs from HI_CYC, measured on the first pulse of the first request.

// File: rtl/otp_read_pkg.sv
package otp_read_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UP_STBY,
        S_UP_TRIM,
        S_UP_CE,
        S_ADDR,
        S_CLK_HI,
        S_CLK_LO,
        S_EMIT,
        S_DN_CE,
        S_DN_TRIM,
        S_FINISH
    } otp_state_e;

    // cycles = ceil(clk_hz * ns / 1e9), never below one
    function automatic int ns_to_cycles(longint clk_hz, longint ns);
        longint c;
        c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/otp_range_check.sv
module otp_range_check #(
    parameter int WORDS = 4096,
    parameter int XW    = 13
) (
    input  logic [XW-1:0] idx,
    input  logic [XW-1:0] cnt,
    output logic          bad
);
    localparam logic [XW:0] LIMIT = (XW+1)'(WORDS);

    logic [XW:0] last_excl;

    always_comb begin
        last_excl = {1'b0, idx} + {1'b0, cnt};
        bad = (cnt == '0) || ({1'b0, idx} >= LIMIT) || (last_excl > LIMIT);
    end
endmodule

// File: rtl/otp_interval_timer.sv
module otp_interval_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] lim,
    output logic          hit
);
    logic [TW-1:0] cnt_q;

    assign hit = run && (cnt_q == lim - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || hit)   cnt_q <= '0;
        else                    cnt_q <= cnt_q + TW'(1);
    end
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
    import otp_read_pkg::*;
#(
    parameter int     WORDS     = 4096,
    parameter int     DATA_W    = 32,
    parameter longint CLK_HZ    = 250_000_000,
    parameter longint ACCESS_NS = 40_000,
    parameter longint LOW_NS    = 10_000,
    localparam int    AW        = $clog2(WORDS),
    localparam int    XW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XW-1:0]     req_idx,
    input  logic [XW-1:0]     req_cnt,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              err,
    output logic              done,
    output logic [AW-1:0]     otp_addr,
    output logic              otp_clk,
    output logic              otp_ce,
    output logic              otp_trim,
    output logic              otp_stby_n,
    output logic              otp_prog,
    output logic              otp_we,
    output logic              otp_tmode,
    input  logic [DATA_W-1:0] otp_rdata
);
    localparam int HI_CYC = ns_to_cycles(CLK_HZ, ACCESS_NS);
    localparam int LO_CYC = ns_to_cycles(CLK_HZ, LOW_NS);
    localparam int MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int TW = $clog2(MAX_CYC + 1);

    otp_state_e          state_q, state_d;
    logic [AW-1:0]       addr_q;
    logic [XW-1:0]       left_q;
    logic [DATA_W-1:0]   word_q;
    logic                err_q;
    logic                bad;
    logic                tmr_run, tmr_hit;
    logic [TW-1:0]       tmr_lim;
    logic                take_req, take_word, last_word;

    otp_range_check #(.WORDS(WORDS), .XW(XW)) u_range (
        .idx (req_idx),
        .cnt (req_cnt),
        .bad (bad)
    );

    assign tmr_run = (state_q == S_CLK_HI) || (state_q == S_CLK_LO);
    assign tmr_lim = (state_q == S_CLK_HI) ? TW'(HI_CYC) : TW'(LO_CYC);

    otp_interval_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .lim   (tmr_lim),
        .hit   (tmr_hit)
    );

    assign take_req  = (state_q == S_IDLE) && req_valid;
    assign take_word = (state_q == S_EMIT) && out_ready;
    assign last_word = (left_q == XW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take_req && !bad) state_d = S_UP_STBY;
            S_UP_STBY: state_d = S_UP_TRIM;
            S_UP_TRIM: state_d = S_UP_CE;
            S_UP_CE:   state_d = S_ADDR;
            S_ADDR:    state_d = S_CLK_HI;
            S_CLK_HI:  if (tmr_hit) state_d = S_CLK_LO;
            S_CLK_LO:  if (tmr_hit) state_d = S_EMIT;
            S_EMIT:    if (out_ready) state_d = last_word ? S_DN_CE : S_ADDR;
            S_DN_CE:   state_d = S_DN_TRIM;
            S_DN_TRIM: state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        out_valid  = 1'b0;
        done       = 1'b0;
        otp_stby_n = 1'b0;
        otp_trim   = 1'b0;
        otp_ce     = 1'b0;
        otp_clk    = 1'b0;
        unique case (state_q)
            S_IDLE:    req_ready = 1'b1;
            S_UP_STBY: otp_stby_n = 1'b1;
            S_UP_TRIM: begin otp_stby_n = 1'b1; otp_trim = 1'b1; end
            S_UP_CE, S_ADDR, S_CLK_LO: begin
                otp_stby_n = 1'b1; otp_trim = 1'b1; otp_ce = 1'b1;
            end
            S_CLK_HI: begin
                otp_stby_n = 1'b1; otp_trim = 1'b1; otp_ce = 1'b1; otp_clk = 1'b1;
            end
            S_EMIT: begin
                otp_stby_n = 1'b1; otp_trim = 1'b1; otp_ce = 1'b1; out_valid = 1'b1;
            end
            S_DN_CE:   begin otp_stby_n = 1'b1; otp_trim = 1'b1; end
            S_DN_TRIM: otp_stby_n = 1'b1;
            S_FINISH:  done = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign otp_prog  = 1'b0;
    assign otp_we    = 1'b0;
    assign otp_tmode = 1'b0;
    assign otp_addr  = addr_q;
    assign out_data  = word_q;
    assign err       = err_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= take_req && bad;
            if (take_req && !bad) begin
                addr_q <= req_idx[AW-1:0];
                left_q <= req_cnt;
            end
            if ((state_q == S_CLK_LO) && tmr_hit)
                word_q <= otp_rdata;
            if (take_word) begin
                left_q <= left_q - XW'(1);
                if (!last_word) addr_q <= addr_q + AW'(1);
            end
        end
    end
endmodule

// File: rtl/otp_read_seq_chk.sv
module otp_read_seq_chk #(
    parameter int AW     = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              err,
    input logic              done,
    input logic [AW-1:0]     otp_addr,
    input logic              otp_clk,
    input logic              otp_ce,
    input logic              otp_trim,
    input logic              otp_stby_n
);
    p_err_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid && req_ready));
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !otp_stby_n && !otp_trim && !otp_ce && !otp_clk);
    p_nest_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        otp_ce |-> otp_trim && otp_stby_n);
    p_trim_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(otp_trim) |-> $past(otp_stby_n));
    p_ce_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(otp_ce) |-> $past(otp_trim));
    p_clk_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        otp_clk |-> otp_ce);
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        otp_clk |-> $stable(otp_addr));
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    p_stall_noclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !otp_clk);
    p_done_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !otp_stby_n && $past(otp_stby_n) && !$past(otp_trim));
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        otp_stby_n |-> !req_ready);
endmodule

bind otp_read_seq otp_read_seq_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .err        (err),
    .done       (done),
    .otp_addr   (otp_addr),
    .otp_clk    (otp_clk),
    .otp_ce     (otp_ce),
    .otp_trim   (otp_trim),
    .otp_stby_n (otp_stby_n)
);

// File: tb/sim_otp_read_seq.sv
module sim_otp_read_seq;
    localparam int WORDS = 64;
    localparam int AW    = 6;
    localparam int XW    = 7;
    localparam int DW    = 32;
    // 250 MHz: 38 ns -> 9.5 -> 10 cycles, 17 ns -> 4.25 -> 5 cycles (R10 rounding up)
    localparam int EXP_HI = 10;
    localparam int EXP_LO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [XW-1:0] req_idx = '0;
    logic [XW-1:0] req_cnt = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic err, done;
    logic [AW-1:0] otp_addr;
    logic otp_clk, otp_ce, otp_trim, otp_stby_n, otp_prog, otp_we, otp_tmode;
    logic [DW-1:0] otp_rdata = '0;

    always #2 clk = ~clk;

    otp_read_seq #(.WORDS(WORDS), .DATA_W(DW), .CLK_HZ(250_000_000),
                   .ACCESS_NS(38), .LOW_NS(17)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_cnt(req_cnt), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .err(err), .done(done),
        .otp_addr(otp_addr), .otp_clk(otp_clk), .otp_ce(otp_ce),
        .otp_trim(otp_trim), .otp_stby_n(otp_stby_n), .otp_prog(otp_prog),
        .otp_we(otp_we), .otp_tmode(otp_tmode), .otp_rdata(otp_rdata)
    );

    function automatic logic [DW-1:0] fuse_val(int i);
        return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0103) ^ {26'd0, 6'(i)} << 20;
    endfunction

    // behavioural fuse macro
    always @(posedge otp_clk)
        otp_rdata <= (otp_ce && otp_trim && otp_stby_n) ? fuse_val(int'(otp_addr)) : 32'hDEAD_BEEF;

    int n_chk = 0;
    int n_err = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_q[$];

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // consumer ready, changed after the edge
    int cyc = 0;
    always @(posedge clk) out_ready <= stall_mode ? ((cyc % 7) < 3) : 1'b1;

    // monitor
    int t_stby_up, t_trim_up, t_ce_dn, t_trim_dn, t_clk_up, t_clk_dn;
    int pin_ev = 0;
    logic p_stby = 0, p_trim = 0, p_ce = 0, p_clk = 0, p_valid = 0, p_stall = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (otp_stby_n != p_stby || otp_trim != p_trim || otp_ce != p_ce ||
                otp_clk != p_clk || otp_addr != p_addr) pin_ev++;
            if (otp_stby_n && !p_stby) t_stby_up = cyc;
            if (otp_trim && !p_trim) t_trim_up = cyc;
            if (!otp_ce && p_ce) t_ce_dn = cyc;
            if (!otp_trim && p_trim) t_trim_dn = cyc;
            if (otp_ce && !p_ce) begin
                chk(t_trim_up == cyc - 1 && t_stby_up == cyc - 2, "R3 power-up order",
                    cyc - t_trim_up, 1);
            end
            if (otp_clk && !p_clk) begin
                t_clk_up = cyc;
                chk(otp_addr == p_addr, "R4 address setup", otp_addr, p_addr);
                chk(!otp_prog && !otp_we && !otp_tmode, "R9 program pins idle",
                    {otp_prog, otp_we, otp_tmode}, 0);
            end
            if (!otp_clk && p_clk) begin
                t_clk_dn = cyc;
                chk(cyc - t_clk_up == EXP_HI, "R4/R10 clock high width", cyc - t_clk_up, EXP_HI);
            end
            if (otp_clk)
                chk(otp_addr == p_addr, "R4 address held", otp_addr, p_addr);
            if (out_valid && !p_valid) begin
                chk(cyc - t_clk_dn >= EXP_LO, "R5/R10 clock low interval", cyc - t_clk_dn, EXP_LO);
                chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
            end
            if (out_valid && p_stall) begin
                chk(out_data == p_data && !otp_clk, "R7 stall hold", out_data, p_data);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", out_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R5/R6 word value", out_data, e);
                end
            end
            if (done) begin
                chk(!otp_stby_n && t_trim_dn == cyc - 1 && t_ce_dn == cyc - 2,
                    "R8 power-down order", cyc - t_ce_dn, 2);
            end
        end
        p_stby = otp_stby_n; p_trim = otp_trim; p_ce = otp_ce; p_clk = otp_clk;
        p_addr = otp_addr; p_valid = out_valid; p_data = out_data;
        p_stall = out_valid && !out_ready;
    end

    task automatic send(int idx, int cnt);
        bit bad;
        int ev0;
        bad = (cnt == 0) || (idx >= WORDS) || (idx + cnt > WORDS);
        if (!bad) for (int i = 0; i < cnt; i++) exp_q.push_back(fuse_val(idx + i));
        @(negedge clk);
        req_valid = 1'b1; req_idx = XW'(idx); req_cnt = XW'(cnt);
        while (!req_ready) @(negedge clk);
        ev0 = pin_ev;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == bad, "R2 error pulse", err, bad);
        if (bad) begin
            @(negedge clk);
            chk(err == 1'b0, "R2 single-cycle error", err, 0);
            repeat (3) @(negedge clk);
            chk(pin_ev == ev0 && req_ready, "R2 pins quiet", pin_ev - ev0, 0);
        end else begin
            chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
            while (!done) @(negedge clk);
            chk(exp_q.size() == 0, "R6 word count", exp_q.size(), 0);
            @(negedge clk);
            chk(!done && req_ready && !otp_stby_n, "R8 single done", done, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !otp_stby_n && !otp_trim && !otp_ce && !otp_clk &&
            !out_valid && !done && !err, "R1 reset state", req_ready, 1);
        rst_n = 1'b1;
        send(0, 3);
        stall_mode = 1'b1;
        send(10, 5);
        stall_mode = 1'b0;
        send(60, 4);
        send(63, 1);
        send(64, 1);
        send(60, 5);
        send(5, 0);
        send(127, 1);
        stall_mode = 1'b1;
        send(62, 2);
        chk(!otp_prog && !otp_we && !otp_tmode, "R9 idle program pins",
            {otp_prog, otp_we, otp_tmode}, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule